// File: doc/BRIEF.md
# GPIO Interrupt Summary Aggregator

This block gathers the pending interrupt and wake flags of a 192-pin GPIO array and reduces them to a grouped summary. Each summary bit stands for four adjacent pins. From that summary it drives a single interrupt line towards the parent interrupt controller. The per-pin detection logic sits outside the block and presents its pending flags as levels.

The service flow is simple. Software sees the parent line rise and reads the two summary words. It services and clears the pins those words point to, then writes the end-of-interrupt bit. No per-pin acknowledge is needed before service starts. The parent line stays high from the moment it fires until that end-of-interrupt write, even if every pin is cleared first. After the write, the line drops for one cycle. It then fires again at once if any summary bit is still set, so a pin that became pending during service is not lost.

Registers are reached through a plain read/write port with byte addresses.

Top module: `gpio_irq_summary`

## Requirements
- R1: Summary bit k (k = 0..45) is 1 in the cycle after any of pins 4k, 4k+1, 4k+2 or 4k+3 shows a pending interrupt or a pending wake flag. Both kinds of flag count alike.
- R2: Summary bits are read as two words:
  - Reading address 0x2F8 returns bits 0..31.
  - Reading address 0x2FC returns bits 32..45 in data bits 13:0, and data bits 31:14 read 0.
  - Pins 184..191 never affect any summary bit.
- R3: While the block is armed and the line is low, the line rises on the clock edge after the summary first becomes non-zero. That is two edges after the pin input. With an all-zero summary, the line stays low.
- R4: Once high, the line stays high until an end-of-interrupt write, whatever the summary does in the meantime.
- R5: An end-of-interrupt is a write to address 0xFC with data bit 29 set. A write to 0xFC with bit 29 clear has no effect on the line, and neither has a write to any other address.
- R6: The edge that takes an end-of-interrupt write drops the line. On the following edge the line rises again if the summary is non-zero; otherwise it stays low.
- R7: Address 0xFC reads as 0, because the end-of-interrupt bit clears itself. Every address other than 0x2F8 and 0x2FC also reads as 0.
- R8: In reset (rst_n low at a clock edge) the line, the summary and the read data are all 0.
- R9: The summary is not sticky. It follows the pin flags one cycle later, so clearing the pins clears it. A read returns its data on the edge that samples reg_rd high, and reg_rdata holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_int_pend | input | 192 | Per-pin interrupt pending flags (levels) |
| pin_wake_pend | input | 192 | Per-pin wake pending flags (levels) |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 10 | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| irq_out | output | 1 | Parent interrupt line |

## Verification
A summary register that has stopped following its pins shows up in two places. The next read of the summary words is wrong, and the parent line does not rise two edges after the pin input. A service latch that clears early or never clears shows on irq_out within one edge: the line falls while in service without an end-of-interrupt write, or it stays high after one. The stimulus is built to make these visible: random sparse pin patterns, pins only at the group edges, writes to the master register without the end-of-interrupt bit, and end-of-interrupt writes with pins still pending.

// File: rtl/gis_pkg.sv
`timescale 1ns/1ps
// Shared sizes and register offsets of the GPIO interrupt summary aggregator.
package gis_pkg;
    localparam int PIN_CNT    = 192;   // pins presented by the detection logic
    localparam int GRP_SIZE   = 4;     // pins folded into one summary bit
    localparam int GRP_USED   = 46;    // summary bits that carry meaning
    localparam int REG_W      = 32;    // register data width
    localparam int ADDR_W     = 10;    // byte address width
    localparam int EOI_BIT    = 29;    // end-of-interrupt bit in the master register
    localparam logic [ADDR_W-1:0] OFF_MASTER = 10'h0FC;
    localparam logic [ADDR_W-1:0] OFF_SUM_LO = 10'h2F8;
    localparam logic [ADDR_W-1:0] OFF_SUM_HI = 10'h2FC;
endpackage

// File: rtl/gis_group_or.sv
`timescale 1ns/1ps
// Group OR stage: folds the interrupt and wake flags of each group of
// GRP_SIZE consecutive pins into one registered summary bit.
// Assumes: pin flags are levels held by the per-pin logic until cleared,
// and GRP_USED*GRP_SIZE <= PIN_CNT.
module gis_group_or #(
    parameter int PIN_CNT  = 192,
    parameter int GRP_SIZE = 4,
    parameter int GRP_USED = 46,
    localparam int USED_PINS = GRP_USED * GRP_SIZE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [USED_PINS-1:0] int_pend,
    input  logic [USED_PINS-1:0] wake_pend,
    output logic [GRP_USED-1:0]  sum_q,
    output logic                 sum_any
);
    logic [GRP_USED-1:0] sum_d;

    // One OR reduction per group of pins.
    for (genvar g = 0; g < GRP_USED; g++) begin : g_grp
        assign sum_d[g] = |(int_pend[g*GRP_SIZE +: GRP_SIZE] |
                            wake_pend[g*GRP_SIZE +: GRP_SIZE]);
    end

    // Register the summary so that it follows the pins one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end

    // Any group pending, taken from the registered summary.
    assign sum_any = |sum_q;
endmodule

// File: rtl/gis_svc_ctrl.sv
`timescale 1ns/1ps
// Service latch: arms the parent line, holds it through service and
// re-arms only on an end-of-interrupt pulse.
// Assumes: eoi is a single-cycle pulse from the register port.
module gis_svc_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic sum_any,
    input  logic eoi,
    output logic in_svc
);
    // Armed -> in service on a pending summary; in service -> armed on end of interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_svc <= 1'b0;
        end else if (in_svc) begin
            if (eoi) in_svc <= 1'b0;
        end else if (sum_any) begin
            in_svc <= 1'b1;
        end
    end
endmodule

// File: rtl/gis_csr.sv
`timescale 1ns/1ps
// Register port: decodes the end-of-interrupt write and returns the
// summary words on reads; every other address reads as zero.
// Assumes: byte addresses, word-aligned accesses, GRP_USED <= 2*REG_W.
module gis_csr
    import gis_pkg::*;
#(
    parameter int GRP_USED = 46
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [GRP_USED-1:0] sum_q,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              eoi_pulse
);
    localparam int EXT_W = 2 * REG_W;

    logic [EXT_W-1:0] sum_ext;
    logic [REG_W-1:0] rd_mux;
    logic             unused_wdata;

    // Zero-extend the summary to two full words.
    assign sum_ext = {{(EXT_W-GRP_USED){1'b0}}, sum_q};

    // End of interrupt: master register write with its bit set; nothing is stored.
    assign eoi_pulse = reg_wr && (reg_addr == OFF_MASTER) && reg_wdata[EOI_BIT];

    // The other write data bits have no storage behind them.
    assign unused_wdata = ^(reg_wdata & ~(REG_W'(1) << EOI_BIT));

    // Read multiplexer over the two summary words.
    always_comb begin
        case (reg_addr)
            OFF_SUM_LO: rd_mux = sum_ext[REG_W-1:0];
            OFF_SUM_HI: rd_mux = sum_ext[EXT_W-1:REG_W];
            default:    rd_mux = '0;
        endcase
    end

    // Capture read data on the read strobe and hold it until the next read.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end
endmodule

// File: rtl/gpio_irq_summary.sv
`timescale 1ns/1ps
// GPIO interrupt summary aggregator (top). Folds 192 pin flags into a
// 46-bit grouped summary and drives one parent interrupt line that is
// re-armed by an end-of-interrupt write.
// Assumes: pin flags are synchronous levels; pins past GRP_USED*GRP_SIZE are ignored.
module gpio_irq_summary
    import gis_pkg::*;
#(
    parameter int NPINS  = PIN_CNT,
    parameter int GSIZE  = GRP_SIZE,
    parameter int NGROUP = GRP_USED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_int_pend,
    input  logic [NPINS-1:0]  pin_wake_pend,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq_out
);
    localparam int USED_PINS = NGROUP * GSIZE;

    logic [NGROUP-1:0] sum_q;
    logic              sum_any;
    logic              eoi_pulse;
    logic              in_svc;

    // Pins beyond the meaningful groups feed nothing.
    if (USED_PINS < NPINS) begin : g_spare
        logic unused_pins;
        assign unused_pins = ^{pin_int_pend[NPINS-1:USED_PINS],
                               pin_wake_pend[NPINS-1:USED_PINS]};
    end

    gis_group_or #(
        .PIN_CNT  (NPINS),
        .GRP_SIZE (GSIZE),
        .GRP_USED (NGROUP)
    ) u_grp (
        .clk       (clk),
        .rst_n     (rst_n),
        .int_pend  (pin_int_pend[USED_PINS-1:0]),
        .wake_pend (pin_wake_pend[USED_PINS-1:0]),
        .sum_q     (sum_q),
        .sum_any   (sum_any)
    );

    gis_csr #(
        .GRP_USED (NGROUP)
    ) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .sum_q     (sum_q),
        .reg_rdata (reg_rdata),
        .eoi_pulse (eoi_pulse)
    );

    gis_svc_ctrl u_svc (
        .clk     (clk),
        .rst_n   (rst_n),
        .sum_any (sum_any),
        .eoi     (eoi_pulse),
        .in_svc  (in_svc)
    );

    // The parent line is the service latch itself.
    assign irq_out = in_svc;
endmodule

// File: rtl/gis_checker.sv
`timescale 1ns/1ps
// Property checker for the GPIO interrupt summary aggregator, bound to the top.
module gis_checker
    import gis_pkg::*;
#(
    parameter int USED_PINS = 184
) (
    input logic              clk,
    input logic              rst_n,
    input logic [USED_PINS-1:0] int_used,
    input logic [USED_PINS-1:0] wake_used,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              sum_any,
    input logic              eoi,
    input logic              irq
);
    // R1: any pending pin in a meaningful group gives a non-empty summary next cycle
    a_r1_pend_to_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (|(int_used | wake_used)) |=> sum_any);
    // R9: no pending pins gives an empty summary next cycle
    a_r9_sum_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(int_used | wake_used)) |=> !sum_any);
    // R3: armed with a pending summary, the line rises next edge
    a_r3_arm_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && sum_any) |=> irq);
    // R3: armed with an empty summary, the line stays low
    a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !sum_any) |=> !irq);
    // R4: in service without end of interrupt, the line is held
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !eoi) |=> irq);
    // R6: end of interrupt in service drops the line
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && eoi) |=> !irq);
    // R2: the upper summary word has zero above bit 13
    a_r2_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFF_SUM_HI) |=> (reg_rdata[REG_W-1:14] == '0));
    // R7: the master register reads zero
    a_r7_master_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFF_MASTER) |=> (reg_rdata == '0));
    // R8: reset clears the line and the read data
    a_r8_reset: assert property (@(posedge clk)
        !rst_n |=> (!irq && reg_rdata == '0));
endmodule

bind gpio_irq_summary gis_checker #(.USED_PINS(USED_PINS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .int_used  (pin_int_pend[USED_PINS-1:0]),
    .wake_used (pin_wake_pend[USED_PINS-1:0]),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .sum_any   (sum_any),
    .eoi       (eoi_pulse),
    .irq       (irq_out)
);

// File: tb/gpio_irq_summary_tb.sv
`timescale 1ns/1ps
module gpio_irq_summary_tb_top;
    import gis_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [191:0]      pin_int = '0;
    logic [191:0]      pin_wake = '0;
    logic              reg_rd = 1'b0;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [REG_W-1:0]  reg_wdata = '0;
    logic [REG_W-1:0]  reg_rdata;
    logic              irq_out;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    gpio_irq_summary dut_i (
        .clk(clk), .rst_n(rst_n),
        .pin_int_pend(pin_int), .pin_wake_pend(pin_wake),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [REG_W-1:0] d);
        reg_addr = a; reg_rd = 1'b1;
        step();
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [REG_W-1:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        step();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    // Expected grouped summary from the requirement (46 groups of four pins).
    function automatic logic [63:0] exp_sum(input logic [191:0] a, input logic [191:0] b);
        logic [63:0] r = '0;
        for (int k = 0; k < 46; k++) r[k] = |(a[4*k +: 4] | b[4*k +: 4]);
        return r;
    endfunction

    function automatic logic [191:0] sparse192();
        logic [191:0] v;
        for (int i = 0; i < 6; i++) v[32*i +: 32] = $urandom() & $urandom() & $urandom();
        return v;
    endfunction

    logic [REG_W-1:0] d, d2;
    logic [63:0] e;

    initial begin
        void'($urandom(32'h5EED_1234));
        step(); step();
        // R8: reset state
        chk("R8 irq in reset", {63'd0, irq_out}, 64'd0);
        chk("R8 rdata in reset", {32'd0, reg_rdata}, 64'd0);
        pin_int[0] = 1'b1;   // pending during reset must not fire
        step();
        chk("R8 irq with pin pending in reset", {63'd0, irq_out}, 64'd0);
        pin_int = '0;
        step(); step();
        rst_n = 1'b1;
        step(); step();
        rd(OFF_SUM_LO, d);
        chk("R8 summary after reset", {32'd0, d}, 64'd0);

        // R2: pins 184..191 are ignored
        pin_int[191:184] = 8'hFF; pin_wake[191:184] = 8'hFF;
        step(); step();
        chk("R2 spare pins no irq", {63'd0, irq_out}, 64'd0);
        rd(OFF_SUM_HI, d);
        chk("R2 spare pins hi word", {32'd0, d}, 64'd0);
        pin_int = '0; pin_wake = '0;

        // R1/R2: wake on pin 183 lands in bit 13 of the upper word
        pin_wake[183] = 1'b1;
        step();
        chk("R3 irq not yet one edge after pin", {63'd0, irq_out}, 64'd0);
        step();
        chk("R3 irq two edges after pin", {63'd0, irq_out}, 64'd1);
        rd(OFF_SUM_HI, d);
        chk("R2 pin 183 in hi bit 13", {32'd0, d}, 64'h2000);
        rd(OFF_SUM_LO, d);
        chk("R1 lo word empty", {32'd0, d}, 64'd0);

        // R5: writes without the end-of-interrupt bit, or elsewhere, do nothing
        pin_wake = '0;
        wr(OFF_MASTER, ~(32'd1 << 29));
        chk("R5 master write without bit 29", {63'd0, irq_out}, 64'd1);
        wr(OFF_SUM_LO, 32'd1 << 29);
        chk("R5 bit 29 to other address", {63'd0, irq_out}, 64'd1);
        step();
        chk("R4 held with empty summary", {63'd0, irq_out}, 64'd1);

        // R7: master register and unmapped addresses read zero
        rd(OFF_MASTER, d);
        chk("R7 master reads zero", {32'd0, d}, 64'd0);
        rd(10'h100, d);
        chk("R7 unmapped reads zero", {32'd0, d}, 64'd0);

        // R6: end of interrupt with nothing pending -> stays low
        wr(OFF_MASTER, 32'd1 << 29);
        chk("R6 eoi drops line", {63'd0, irq_out}, 64'd0);
        step();
        chk("R6 stays low when empty", {63'd0, irq_out}, 64'd0);

        // R6: end of interrupt with a pin still pending -> low one cycle then high
        pin_int[4] = 1'b1;
        step(); step();
        chk("R3 fire on pin 4", {63'd0, irq_out}, 64'd1);
        rd(OFF_SUM_LO, d);
        chk("R1 pin 4 in bit 1", {32'd0, d}, 64'h2);
        wr(OFF_MASTER, 32'd1 << 29);
        chk("R6 eoi drops line with pending", {63'd0, irq_out}, 64'd0);
        step();
        chk("R6 refire after eoi", {63'd1, irq_out} & 64'd1, 64'd1);
        pin_int = '0;
        step(); step();
        wr(OFF_MASTER, 32'd1 << 29);
        step();

        // Random sparse patterns against the computed summary
        for (int it = 0; it < 300; it++) begin
            pin_int  = (it % 7 == 0) ? '0 : sparse192();
            pin_wake = (it % 5 == 0) ? '0 : sparse192();
            e = exp_sum(pin_int, pin_wake);
            step();
            chk("R3 random no early fire", {63'd0, irq_out}, 64'd0);
            step();
            chk("R3 random fire", {63'd0, irq_out}, {63'd0, |e});
            rd(OFF_SUM_LO, d);
            rd(OFF_SUM_HI, d2);
            chk("R1 random summary", {d2, d}, e);
            pin_int = '0; pin_wake = '0;
            step(); step();
            chk("R4 random hold", {63'd0, irq_out}, {63'd0, |e});
            rd(OFF_SUM_LO, d);
            chk("R9 summary clears", {32'd0, d}, 64'd0);
            wr(OFF_MASTER, 32'd1 << 29);
            chk("R6 random release", {63'd0, irq_out}, 64'd0);
            step();
            chk("R6 random stays low", {63'd0, irq_out}, 64'd0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule